// File: doc/BRIEF.md
# Memory Ordering Group Tracker

This block sits at the dispatch point of an out-of-order load/store unit. Each dispatched memory operation (a load, a store, or an operation that does both, optionally marked as a barrier) is placed into a memory group. Each new group records which older groups must finish before it may issue. A run of ordinary loads with no store or barrier between them shares one group, so they can issue together. Every store and every barrier opens a group of its own, with explicit ordering edges to the groups it must not pass.

The scheduler uses the block in three ways. It presents a dispatch request and reads the offered group ID and a status code in the same cycle. It reports execute-start and execute-done events tagged with the group ID, and it reports retire events that hand back queue slots. It can ask whether any in-flight group is free to issue through a query port. A group leaves the table once all its members have executed. Any ordering pointer that still names a departed group is cleared.

Top module: `mem_group_tracker`

## Requirements
- R1: Group IDs are 8 bits wide. The first group after reset gets ID 1 and each new group takes the next value. After 255 the sequence returns to 1, so ID 0 is never given out.
- R2: A plain load (no store, no barrier) joins the youngest load group, and `disp_gid` returns that group's ID, when all of the following hold: the youngest load group exists, it is not a load barrier, no store has been dispatched since it opened, and none of its members has started execution.
- R3: A plain load opens a new group in each of these cases: no load group is in flight, the youngest load group is a load barrier, a store was dispatched after it, or one of its members has started executing. A barrier load also always opens a new group.
- R4: Every store opens a new group. That group waits on the youngest load group (or the load barrier if no ordinary load group remains), on the current store barrier, and on the current store group.
- R5: A new load group waits on the current store group unless `no_alias` is 1. A barrier load also waits on the youngest load group. An ordinary load that opens a group waits on the current load barrier instead.
- R6: `issue_ready` is 1 for the queried ID only when that group is in flight and every group it waits on has been freed. `query_hit` is 0 for an ID that is not in flight.
- R7: A group is freed in the cycle its executed count reaches its member count. The group then no longer answers queries. A later plain load does not join a freed load group.
- R8: `disp_status` encodes 0 = accepted, 1 = load queue full, 2 = store queue full, 3 = no free group entry. The checks run in the order load queue, store queue, group entry. Entry shortage is reported only when a new group is needed. A request with a nonzero status changes no state.
- R9: `lq_count` rises by one for each accepted operation that loads and falls by one on a retire with `retire_load` set. `sq_count` behaves the same way for stores. Neither exceeds its depth (16 and 12 by default).
- R10: After reset both counters read 0, no ID is in flight, and the first accepted dispatch is offered ID 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request present |
| disp_load | input | 1 | Operation reads memory |
| disp_store | input | 1 | Operation writes memory |
| disp_barrier | input | 1 | Operation is an ordering barrier |
| no_alias | input | 1 | Loads may pass older stores |
| disp_status | output | 2 | Status code for the current request |
| disp_gid | output | 8 | Group ID given to the current request |
| exec_start_valid | input | 1 | A member started execution |
| exec_start_gid | input | 8 | Its group ID |
| exec_done_valid | input | 1 | A member finished execution |
| exec_done_gid | input | 8 | Its group ID |
| retire_valid | input | 1 | An operation retires |
| retire_load | input | 1 | Retiring operation held a load slot |
| retire_store | input | 1 | Retiring operation held a store slot |
| query_gid | input | 8 | Group ID being asked about |
| query_hit | output | 1 | Queried group is in flight |
| issue_ready | output | 1 | Queried group may issue |
| lq_count | output | 5 | Load queue occupancy |
| sq_count | output | 4 | Store queue occupancy |

## Verification
Some properties are checked on every cycle. Occupancy never passes the queue depths and moves by exactly one on an accepted dispatch. The status code follows its priority order whenever a queue is full. A query for ID 0 never hits, and readiness is never reported for an ID that is not in flight. The grouping decisions and the ordering edges can only be shown by the bench's scenarios. These cover loads joining or splitting around stores, barriers and started groups, and readiness appearing only after the right predecessors are freed. The scenarios also cover the no-alias exception, pointer clearing after a group leaves, the ID wrap past 255, and status priority with both queues full.

// File: rtl/mgt_pkg.sv
package mgt_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_LQ_FULL = 2'd1,
    ST_SQ_FULL = 2'd2,
    ST_NO_SLOT = 2'd3
  } disp_status_e;
endpackage

// File: rtl/mgt_occupancy.sv
module mgt_occupancy #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          full
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_inc, do_dec, cnt_en;

  always_comb begin
    do_inc = inc && (cnt_q != CNT_MAX);
    do_dec = dec && (cnt_q != '0);
    cnt_en = do_inc ^ do_dec;
    cnt_d  = cnt_q;
    if (do_inc && !do_dec) cnt_d = cnt_q + CW'(1);
    if (do_dec && !do_inc) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign full  = (cnt_q == CNT_MAX);
endmodule

// File: rtl/mgt_group_slot.sv
module mgt_group_slot #(
  parameter int GID_W      = 8,
  parameter int IC_W       = 5,
  parameter int PC_W       = 4,
  parameter int NUM_GROUPS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc,
  input  logic [GID_W-1:0]      alloc_gid,
  input  logic [NUM_GROUPS-1:0] alloc_preds,
  input  logic                  join_inc,
  input  logic                  start_inc,
  input  logic                  done_inc,
  input  logic [NUM_GROUPS-1:0] free_oh,
  output logic                  valid,
  output logic [GID_W-1:0]      gid,
  output logic                  started,
  output logic                  ready,
  output logic                  freeing
);
  logic                  valid_q, valid_d;
  logic [GID_W-1:0]      gid_q, gid_d;
  logic [IC_W-1:0]       inst_q, inst_d, start_q, start_d, done_q, done_d;
  logic [NUM_GROUPS-1:0] waits_q, waits_d;
  logic [PC_W-1:0]       pred_q, pred_d, pdone_q, pdone_d;
  logic                  pred_hit, slot_en;

  always_comb begin
    pred_hit = valid_q && ((free_oh & waits_q) != '0);
    freeing  = valid_q && done_inc && ((done_q + IC_W'(1)) == inst_q);
    slot_en  = alloc || join_inc || start_inc || done_inc || pred_hit;
    valid_d  = valid_q;
    gid_d    = gid_q;
    inst_d   = inst_q;
    start_d  = start_q;
    done_d   = done_q;
    waits_d  = waits_q;
    pred_d   = pred_q;
    pdone_d  = pdone_q;
    if (alloc) begin
      valid_d = 1'b1;
      gid_d   = alloc_gid;
      inst_d  = IC_W'(1);
      start_d = '0;
      done_d  = '0;
      waits_d = alloc_preds;
      pred_d  = PC_W'($countones(alloc_preds));
      pdone_d = '0;
    end else begin
      if (join_inc)  inst_d  = inst_q + IC_W'(1);
      if (start_inc) start_d = start_q + IC_W'(1);
      if (done_inc)  done_d  = done_q + IC_W'(1);
      if (pred_hit) begin
        pdone_d = pdone_q + PC_W'(1);
        waits_d = waits_q & ~free_oh;
      end
      if (freeing) valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      gid_q   <= '0;
      inst_q  <= '0;
      start_q <= '0;
      done_q  <= '0;
      waits_q <= '0;
      pred_q  <= '0;
      pdone_q <= '0;
    end else if (slot_en) begin
      valid_q <= valid_d;
      gid_q   <= gid_d;
      inst_q  <= inst_d;
      start_q <= start_d;
      done_q  <= done_d;
      waits_q <= waits_d;
      pred_q  <= pred_d;
      pdone_q <= pdone_d;
    end
  end

  assign valid   = valid_q;
  assign gid     = gid_q;
  assign started = (start_q != '0);
  assign ready   = valid_q && (pdone_q == pred_q);
endmodule

// File: rtl/mgt_dispatch_ctl.sv
module mgt_dispatch_ctl #(
  parameter int GID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_load,
  input  logic             disp_store,
  input  logic             disp_barrier,
  input  logic             no_alias,
  input  logic             accept,
  input  logic             dom_started,
  input  logic             free_valid,
  input  logic [GID_W-1:0] free_gid,
  output logic             need_new,
  output logic [GID_W-1:0] offer_gid,
  output logic [GID_W-1:0] dom_gid,
  output logic [GID_W-1:0] dep_a,
  output logic [GID_W-1:0] dep_b,
  output logic [GID_W-1:0] dep_c
);
  localparam logic [GID_W-1:0] GID_NONE  = '0;
  localparam logic [GID_W-1:0] GID_FIRST = GID_W'(1);
  localparam logic [GID_W-1:0] GID_LAST  = '1;

  // ld: youngest load group, lb: load barrier, sg: store group, sb: store barrier
  logic [GID_W-1:0] ld_q, ld_d, lb_q, lb_d, sg_q, sg_d, sb_q, sb_d;
  logic [GID_W-1:0] next_q, next_d;
  logic             st_after_q, st_after_d;
  logic             load_opens, ctl_en;

  always_comb begin
    dom_gid    = (ld_q != GID_NONE) ? ld_q : lb_q;
    load_opens = disp_barrier || (dom_gid == GID_NONE) || (dom_gid == lb_q) ||
                 ((sg_q != GID_NONE) && st_after_q) || dom_started;
    need_new   = disp_store || load_opens;
    offer_gid  = need_new ? next_q : ld_q;
    if (disp_store) begin
      dep_a = dom_gid;
      dep_b = sb_q;
      dep_c = (sg_q != sb_q) ? sg_q : GID_NONE;
    end else begin
      dep_a = no_alias ? GID_NONE : sg_q;
      dep_b = disp_barrier ? dom_gid : lb_q;
      dep_c = GID_NONE;
    end
  end

  always_comb begin
    ctl_en     = accept || free_valid;
    ld_d       = ld_q;
    lb_d       = lb_q;
    sg_d       = sg_q;
    sb_d       = sb_q;
    st_after_d = st_after_q;
    next_d     = next_q;
    if (free_valid) begin
      if (ld_q == free_gid) ld_d = GID_NONE;
      if (lb_q == free_gid) lb_d = GID_NONE;
      if (sg_q == free_gid) sg_d = GID_NONE;
      if (sb_q == free_gid) sb_d = GID_NONE;
    end
    if (accept) begin
      if (disp_store) begin
        sg_d       = next_q;
        st_after_d = 1'b1;
        if (disp_barrier) sb_d = next_q;
        if (disp_load) begin
          ld_d = next_q;
          if (disp_barrier) lb_d = next_q;
        end
      end else if (load_opens) begin
        ld_d       = next_q;
        st_after_d = 1'b0;
        if (disp_barrier) lb_d = next_q;
      end
      if (need_new) next_d = (next_q == GID_LAST) ? GID_FIRST : next_q + GID_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q       <= GID_NONE;
      lb_q       <= GID_NONE;
      sg_q       <= GID_NONE;
      sb_q       <= GID_NONE;
      st_after_q <= 1'b0;
      next_q     <= GID_FIRST;
    end else if (ctl_en) begin
      ld_q       <= ld_d;
      lb_q       <= lb_d;
      sg_q       <= sg_d;
      sb_q       <= sb_d;
      st_after_q <= st_after_d;
      next_q     <= next_d;
    end
  end
endmodule

// File: rtl/mem_group_tracker.sv
module mem_group_tracker #(
  parameter int LQ_DEPTH   = 16,
  parameter int SQ_DEPTH   = 12,
  parameter int NUM_GROUPS = 8,
  parameter int GID_W      = 8,
  parameter int LQ_CW      = $clog2(LQ_DEPTH + 1),
  parameter int SQ_CW      = $clog2(SQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic             disp_load,
  input  logic             disp_store,
  input  logic             disp_barrier,
  input  logic             no_alias,
  output logic [1:0]       disp_status,
  output logic [GID_W-1:0] disp_gid,
  input  logic             exec_start_valid,
  input  logic [GID_W-1:0] exec_start_gid,
  input  logic             exec_done_valid,
  input  logic [GID_W-1:0] exec_done_gid,
  input  logic             retire_valid,
  input  logic             retire_load,
  input  logic             retire_store,
  input  logic [GID_W-1:0] query_gid,
  output logic             query_hit,
  output logic             issue_ready,
  output logic [LQ_CW-1:0] lq_count,
  output logic [SQ_CW-1:0] sq_count
);
  import mgt_pkg::*;

  localparam int IC_W = $clog2(LQ_DEPTH + SQ_DEPTH + 1);
  localparam int PC_W = $clog2(NUM_GROUPS + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic                  slot_valid [NUM_GROUPS];
  logic [GID_W-1:0]      slot_gid   [NUM_GROUPS];
  logic                  slot_started [NUM_GROUPS];
  logic                  slot_ready [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] freeing, alloc_oh, pred_sel, start_hit;
  logic                  need_new, dom_started, accept, slot_avail;
  logic                  lq_full, sq_full;
  logic [GID_W-1:0]      offer_gid, dom_gid, dep_a, dep_b, dep_c;
  disp_status_e          status;

  always_comb begin
    alloc_oh   = '0;
    slot_avail = 1'b0;
    for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
      if (!slot_valid[i]) begin
        alloc_oh    = '0;
        alloc_oh[i] = 1'b1;
        slot_avail  = 1'b1;
      end
    end
  end

  always_comb begin
    dom_started = 1'b0;
    query_hit   = 1'b0;
    issue_ready = 1'b0;
    for (int i = 0; i < NUM_GROUPS; i++) begin
      if (slot_valid[i] && (slot_gid[i] == dom_gid) && (slot_started[i] || start_hit[i]))
        dom_started = 1'b1;
      if (slot_valid[i] && (slot_gid[i] == query_gid)) begin
        query_hit   = 1'b1;
        issue_ready = slot_ready[i];
      end
    end
  end

  always_comb begin
    if (disp_load && lq_full)        status = ST_LQ_FULL;
    else if (disp_store && sq_full)  status = ST_SQ_FULL;
    else if (need_new && !slot_avail && (disp_load || disp_store)) status = ST_NO_SLOT;
    else                             status = ST_OK;
    accept = disp_valid && (disp_load || disp_store) && (status == ST_OK);
  end

  assign disp_status = status;
  assign disp_gid    = offer_gid;

  mgt_dispatch_ctl #(.GID_W(GID_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .disp_load   (disp_load),
    .disp_store  (disp_store),
    .disp_barrier(disp_barrier),
    .no_alias    (no_alias),
    .accept      (accept),
    .dom_started (dom_started),
    .free_valid  (|freeing),
    .free_gid    (exec_done_gid),
    .need_new    (need_new),
    .offer_gid   (offer_gid),
    .dom_gid     (dom_gid),
    .dep_a       (dep_a),
    .dep_b       (dep_b),
    .dep_c       (dep_c)
  );

  for (genvar i = 0; i < NUM_GROUPS; i++) begin : g_slot
    logic in_use, done_hit, join_hit;
    assign in_use       = slot_valid[i];
    assign start_hit[i] = exec_start_valid && in_use && (slot_gid[i] == exec_start_gid);
    assign done_hit     = exec_done_valid && in_use && (slot_gid[i] == exec_done_gid);
    assign join_hit     = accept && !need_new && in_use && (slot_gid[i] == offer_gid);
    assign pred_sel[i]  = in_use && !freeing[i] &&
                          ((slot_gid[i] == dep_a) || (slot_gid[i] == dep_b) ||
                           (slot_gid[i] == dep_c));

    mgt_group_slot #(
      .GID_W(GID_W), .IC_W(IC_W), .PC_W(PC_W), .NUM_GROUPS(NUM_GROUPS)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .alloc      (accept && need_new && alloc_oh[i]),
      .alloc_gid  (offer_gid),
      .alloc_preds(pred_sel),
      .join_inc   (join_hit),
      .start_inc  (start_hit[i]),
      .done_inc   (done_hit),
      .free_oh    (freeing),
      .valid      (slot_valid[i]),
      .gid        (slot_gid[i]),
      .started    (slot_started[i]),
      .ready      (slot_ready[i]),
      .freeing    (freeing[i])
    );
  end

  mgt_occupancy #(.DEPTH(LQ_DEPTH), .CW(LQ_CW)) u_lq (
    .clk  (clk),
    .rst_n(rst_core_n),
    .inc  (accept && disp_load),
    .dec  (retire_valid && retire_load),
    .count(lq_count),
    .full (lq_full)
  );

  mgt_occupancy #(.DEPTH(SQ_DEPTH), .CW(SQ_CW)) u_sq (
    .clk  (clk),
    .rst_n(rst_core_n),
    .inc  (accept && disp_store),
    .dec  (retire_valid && retire_store),
    .count(sq_count),
    .full (sq_full)
  );
endmodule

// File: rtl/mgt_tracker_checker.sv
module mgt_tracker_checker #(
  parameter int LQ_DEPTH = 16,
  parameter int SQ_DEPTH = 12,
  parameter int GID_W    = 8,
  parameter int LQ_CW    = 5,
  parameter int SQ_CW    = 4
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             disp_valid,
  input logic             disp_load,
  input logic             disp_store,
  input logic [1:0]       disp_status,
  input logic             retire_valid,
  input logic             retire_load,
  input logic             retire_store,
  input logic [GID_W-1:0] query_gid,
  input logic             query_hit,
  input logic             issue_ready,
  input logic [LQ_CW-1:0] lq_count,
  input logic [SQ_CW-1:0] sq_count
);
  p_lq_bound_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    lq_count <= LQ_CW'(LQ_DEPTH));

  p_sq_bound_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    sq_count <= SQ_CW'(SQ_DEPTH));

  p_lq_step_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (disp_valid && disp_load && (disp_status == 2'd0) && !(retire_valid && retire_load))
    |=> (lq_count == $past(lq_count) + LQ_CW'(1)));

  p_sq_step_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (disp_valid && disp_store && (disp_status == 2'd0) && !(retire_valid && retire_store))
    |=> (sq_count == $past(sq_count) + SQ_CW'(1)));

  p_lq_full_first_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (disp_load && (lq_count == LQ_CW'(LQ_DEPTH))) |-> (disp_status == 2'd1));

  p_sq_full_next_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!disp_load && disp_store && (sq_count == SQ_CW'(SQ_DEPTH))) |-> (disp_status == 2'd2));

  p_rejected_hold_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (disp_valid && (disp_status != 2'd0) && !retire_valid)
    |=> ($stable(lq_count) && $stable(sq_count)));

  p_zero_never_hit_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (query_gid == '0) |-> !query_hit);

  p_ready_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    issue_ready |-> query_hit);
endmodule

bind mem_group_tracker mgt_tracker_checker #(
  .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .GID_W(GID_W), .LQ_CW(LQ_CW), .SQ_CW(SQ_CW)
) u_checker (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .disp_valid  (disp_valid),
  .disp_load   (disp_load),
  .disp_store  (disp_store),
  .disp_status (disp_status),
  .retire_valid(retire_valid),
  .retire_load (retire_load),
  .retire_store(retire_store),
  .query_gid   (query_gid),
  .query_hit   (query_hit),
  .issue_ready (issue_ready),
  .lq_count    (lq_count),
  .sq_count    (sq_count)
);

// File: tb/sim_mem_group_tracker.sv
module sim_mem_group_tracker;
  logic       clk;
  logic       rst_n;
  logic       disp_valid, disp_load, disp_store, disp_barrier, no_alias;
  logic [1:0] disp_status;
  logic [7:0] disp_gid;
  logic       exec_start_valid, exec_done_valid;
  logic [7:0] exec_start_gid, exec_done_gid;
  logic       retire_valid, retire_load, retire_store;
  logic [7:0] query_gid;
  logic       query_hit, issue_ready;
  logic [4:0] lq_count;
  logic [3:0] sq_count;

  int checks = 0;
  int errors = 0;

  mem_group_tracker u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {load, store, barrier, no_alias, expected gid, expected status}
  localparam logic [13:0] VECS [12] = '{
    {4'b1000, 8'd1, 2'd0},  // R3 no load in flight
    {4'b1000, 8'd1, 2'd0},  // R2 joins
    {4'b0100, 8'd2, 2'd0},  // R4 store
    {4'b1000, 8'd3, 2'd0},  // R3 store in between
    {4'b1000, 8'd3, 2'd0},  // R2 joins
    {4'b1010, 8'd4, 2'd0},  // R3 barrier load
    {4'b1000, 8'd5, 2'd0},  // R3 after load barrier
    {4'b0110, 8'd6, 2'd0},  // R4 store barrier
    {4'b0100, 8'd7, 2'd0},  // R4 store
    {4'b1001, 8'd8, 2'd0},  // R5 no-alias load
    {4'b1000, 8'd8, 2'd0},  // R2 joins, table full but no new group
    {4'b0100, 8'd9, 2'd3}   // R8 no free entry
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    disp_valid = 0; disp_load = 0; disp_store = 0; disp_barrier = 0; no_alias = 0;
    exec_start_valid = 0; exec_start_gid = 0; exec_done_valid = 0; exec_done_gid = 0;
    retire_valid = 0; retire_load = 0; retire_store = 0; query_gid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
  endtask

  task automatic do_disp(input logic l, input logic s, input logic b, input logic na,
                         input int exp_st, input int exp_gid, input string req);
    @(negedge clk);
    disp_valid = 1; disp_load = l; disp_store = s; disp_barrier = b; no_alias = na;
    #1;
    check({req, " status"}, disp_status, exp_st);
    if (exp_st == 0) check({req, " gid"}, disp_gid, exp_gid);
    @(posedge clk);
    #1;
    disp_valid = 0; disp_load = 0; disp_store = 0; disp_barrier = 0; no_alias = 0;
  endtask

  task automatic exec_grp(input int gid, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      exec_start_valid = 1; exec_start_gid = 8'(gid);
      @(negedge clk);
      exec_start_valid = 0;
      exec_done_valid = 1; exec_done_gid = 8'(gid);
      @(negedge clk);
      exec_done_valid = 0;
    end
  endtask

  task automatic query(input int gid, input int exp_rdy, input int exp_hit, input string req);
    @(negedge clk);
    query_gid = 8'(gid);
    #1;
    check({req, " hit"}, query_hit, exp_hit);
    check({req, " ready"}, issue_ready, exp_rdy);
  endtask

  task automatic do_retire(input logic l, input logic s);
    @(negedge clk);
    retire_valid = 1; retire_load = l; retire_store = s;
    @(posedge clk);
    #1;
    retire_valid = 0; retire_load = 0; retire_store = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    clear_inputs();
    do_reset();

    // R10 reset state
    check("R10 lq_count", lq_count, 0);
    check("R10 sq_count", sq_count, 0);
    query(1, 0, 0, "R10");

    // vector walk: grouping and edges
    for (int i = 0; i < 12; i++)
      do_disp(VECS[i][13], VECS[i][12], VECS[i][11], VECS[i][10],
              int'(VECS[i][1:0]), int'(VECS[i][9:2]), $sformatf("R3 vec%0d", i));
    check("R9 lq_count", lq_count, 8);
    check("R9 sq_count", sq_count, 3);
    query(1, 1, 1, "R6");
    query(2, 0, 1, "R4");
    query(3, 0, 1, "R5");
    exec_grp(1, 2);
    query(1, 0, 0, "R7");
    query(2, 1, 1, "R6");
    query(3, 0, 1, "R5");
    do_disp(0, 1, 0, 0, 0, 9, "R8 entry reused");
    exec_grp(2, 1);
    exec_grp(3, 2);
    exec_grp(4, 1);
    query(8, 1, 1, "R5 no_alias");
    query(5, 1, 1, "R5");
    query(6, 0, 1, "R4");
    query(9, 0, 1, "R4");
    exec_grp(8, 2);
    query(9, 0, 1, "R4");

    // queue fill and status priority
    do_reset();
    for (int k = 1; k <= 12; k++) begin
      do_disp(0, 1, 0, 0, 0, k, "R1 store");
      exec_grp(k, 1);
    end
    check("R9 sq full", sq_count, 12);
    do_disp(0, 1, 0, 0, 2, 0, "R8 sq full");
    for (int k = 0; k < 16; k++) do_disp(1, 0, 0, 0, 0, 13, "R2 load run");
    check("R9 lq full", lq_count, 16);
    do_disp(1, 0, 0, 0, 1, 0, "R8 lq full");
    do_disp(1, 1, 0, 0, 1, 0, "R8 priority");
    do_disp(0, 1, 0, 0, 2, 0, "R8 sq full again");
    check("R8 rejected keeps sq", sq_count, 12);
    do_retire(0, 1);
    check("R9 retire store", sq_count, 11);
    do_retire(1, 0);
    check("R9 retire load", lq_count, 15);
    do_disp(0, 1, 0, 0, 0, 14, "R8 accepted after retire");

    // pointer clear and started-group rule
    do_reset();
    do_disp(1, 0, 0, 0, 0, 1, "R10 first gid");
    exec_grp(1, 1);
    do_disp(1, 0, 0, 0, 0, 2, "R7 freed load not joined");
    @(negedge clk);
    exec_start_valid = 1; exec_start_gid = 8'd2;
    @(negedge clk);
    exec_start_valid = 0;
    do_disp(1, 0, 0, 0, 0, 3, "R3 started group");
    query(3, 1, 1, "R6 no preds");

    // ID wrap
    do_reset();
    for (int k = 1; k <= 255; k++) begin
      do_disp(0, 1, 0, 0, 0, k, "R1 sequence");
      exec_grp(k, 1);
      do_retire(0, 1);
    end
    do_disp(0, 1, 0, 0, 0, 1, "R1 wrap");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule